// File: doc/BRIEF.md
# Addressed Peripheral I/O Slave

This block sits on a simple processor bus as a slave and serves one byte-wide peripheral. Every bus access carries an address whose upper field selects a device and whose low two bits select one of three registers. The block answers only when the device field equals its own identifier. Writes and reads to the three registers decode into the command classes: configure the peripheral, poll status, start a fetch, send a byte, and collect fetched data.

A fetch or send starts a request/acknowledge exchange with the peripheral. The block raises `per_req` and holds it, together with the outgoing byte, until `per_ack` arrives. On that acknowledge a fetched byte is latched into the data register and the done bit is set. Software either polls the status register or, with the interrupt enable set, waits for the level interrupt. Reading the data register returns the byte and clears the interrupt. Transfer and configuration commands that arrive while an exchange is still open are refused and leave an overrun flag. A fault line sampled with the acknowledge leaves a fault flag.

Top module: `iop_slave`

## Requirements
- R1: An access whose device field (`bus_addr[5:2]`, identifier 5 by default) differs from the identifier has no effect: no `bus_rvalid`, no `per_req` and no change to `per_mode`.
- R2: A write to offset 2 stores the control byte. Bit 0 is the interrupt enable, bits 7:4 drive `per_mode`, and a read of offset 2 returns the byte.
- R3: A read of offset 1 returns status one cycle later with `bus_rvalid` high. Status bit 0 is done, bit 1 busy, bit 2 overrun and bit 3 fault. The read clears bits 2 and 3 afterwards.
- R4: A write to offset 1 starts a fetch: `per_req` rises the next cycle with `per_we` low. On the cycle with `per_req` and `per_ack` both high, `per_rdata` is latched, `per_req` falls on the next cycle and done is set.
- R5: A write to offset 0 starts a send: `per_req` rises with `per_we` high and `per_wdata` equal to the bus byte, and both are held unchanged until acknowledged.
- R6: A read of offset 0 returns the data register one cycle later and clears done.
- R7: With the interrupt enable at 0, `irq` stays low even when done is set.
- R8: With the interrupt enable at 1, `irq` is high while done is set and falls after a data-register read.
- R9: While a request is open, writes to offsets 0, 1 and 2 are refused (no new transfer, `per_mode` unchanged) and set the overrun bit.
- R10: `per_fault` high on the acknowledge cycle sets the fault status bit.
- R11: When an acknowledge and a status or data read fall in the same cycle, the read returns the value from before that cycle, and the done bit set by the acknowledge survives the data read.
- R12: Reads and writes to offset 3 have no effect and produce no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe (wins over `bus_rd`) |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 6 | Device field in bits 5:2, register offset in bits 1:0 |
| bus_wdata | input | 8 | Bus write byte |
| bus_rdata | output | 8 | Read result, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | One-cycle read response |
| irq | output | 1 | Level interrupt, active high |
| per_req | output | 1 | Peripheral request |
| per_we | output | 1 | Request direction, 1 = send to peripheral |
| per_wdata | output | 8 | Byte sent to the peripheral |
| per_rdata | input | 8 | Byte from the peripheral, taken on acknowledge |
| per_ack | input | 1 | Peripheral acknowledge |
| per_fault | input | 1 | Peripheral fault, sampled on acknowledge |
| per_mode | output | 4 | Operating mode from the control register |

## Verification
The completion of a peripheral exchange and a processor read of status or data can land on the same clock edge. The bench provokes this by raising `per_ack` in the same cycle as a read of offset 0 or offset 1 while a fetch is open. It expects the read to return the pre-edge contents, meaning a busy-only status or the previous data byte. It also expects done, and with it `irq`, to remain set afterwards. A per-cycle reference model in the bench applies the same ordering and catches any drift on every clock.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int OFF_W = 2;

    localparam logic [OFF_W-1:0] OFF_DATA = 2'd0;
    localparam logic [OFF_W-1:0] OFF_STAT = 2'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL = 2'd2;

    localparam int ST_DONE  = 0;
    localparam int ST_BUSY  = 1;
    localparam int ST_OVR   = 2;
    localparam int ST_FAULT = 3;

    localparam int CT_IE = 0;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CTRL_WR,
        CMD_CTRL_RD,
        CMD_TEST,
        CMD_FETCH,
        CMD_SEND,
        CMD_DATA_RD
    } cmd_e;

endpackage

// File: rtl/iop_decode.sv
module iop_decode
    import iop_pkg::*;
#(
    parameter int              DEV_W  = 4,
    parameter logic [DEV_W-1:0] DEV_ID = 4'h5,
    localparam int             ADDR_W = DEV_W + OFF_W
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output cmd_e              cmd
);

    logic             hit;
    logic [OFF_W-1:0] off;

    assign hit = (bus_addr[ADDR_W-1 -: DEV_W] == DEV_ID);
    assign off = bus_addr[OFF_W-1:0];

    always_comb begin
        cmd = CMD_NONE;
        if (hit) begin
            if (bus_wr) begin
                case (off)
                    OFF_DATA: cmd = CMD_SEND;
                    OFF_STAT: cmd = CMD_FETCH;
                    OFF_CTRL: cmd = CMD_CTRL_WR;
                    default:  cmd = CMD_NONE;
                endcase
            end else if (bus_rd) begin
                case (off)
                    OFF_DATA: cmd = CMD_DATA_RD;
                    OFF_STAT: cmd = CMD_TEST;
                    OFF_CTRL: cmd = CMD_CTRL_RD;
                    default:  cmd = CMD_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/iop_core.sv
module iop_core
    import iop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              irq,
    output logic              per_req,
    output logic              per_we,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_ack,
    input  logic              per_fault,
    output logic [MODE_W-1:0] per_mode
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] wbuf;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              req;
        logic              we;
        logic              done;
        logic              ovr;
        logic              fault;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] status_q;
    logic              finish;

    always_comb begin
        status_q           = '0;
        status_q[ST_DONE]  = st_q.done;
        status_q[ST_BUSY]  = st_q.req;
        status_q[ST_OVR]   = st_q.ovr;
        status_q[ST_FAULT] = st_q.fault;
    end

    assign finish = st_q.req & per_ack;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        case (cmd)
            CMD_CTRL_WR: begin
                if (st_q.req) st_d.ovr  = 1'b1;
                else          st_d.ctrl = wdata;
            end
            CMD_CTRL_RD: begin
                st_d.rdata  = st_q.ctrl;
                st_d.rvalid = 1'b1;
            end
            CMD_TEST: begin
                st_d.rdata  = status_q;
                st_d.rvalid = 1'b1;
                st_d.ovr    = 1'b0;
                st_d.fault  = 1'b0;
            end
            CMD_FETCH: begin
                if (st_q.req) begin
                    st_d.ovr = 1'b1;
                end else begin
                    st_d.req  = 1'b1;
                    st_d.we   = 1'b0;
                    st_d.done = 1'b0;
                end
            end
            CMD_SEND: begin
                if (st_q.req) begin
                    st_d.ovr = 1'b1;
                end else begin
                    st_d.req  = 1'b1;
                    st_d.we   = 1'b1;
                    st_d.wbuf = wdata;
                    st_d.done = 1'b0;
                end
            end
            CMD_DATA_RD: begin
                st_d.rdata  = st_q.data;
                st_d.rvalid = 1'b1;
                st_d.done   = 1'b0;
            end
            default: ;
        endcase
        // completion is applied last so its set wins over a same-cycle clear
        if (finish) begin
            st_d.req  = 1'b0;
            st_d.done = 1'b1;
            if (!st_q.we)  st_d.data  = per_rdata;
            if (per_fault) st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.rdata;
    assign rvalid    = st_q.rvalid;
    assign irq       = st_q.ctrl[CT_IE] & st_q.done;
    assign per_req   = st_q.req;
    assign per_we    = st_q.we;
    assign per_wdata = st_q.wbuf;
    assign per_mode  = st_q.ctrl[DATA_W-1 -: MODE_W];

endmodule

// File: rtl/iop_slave.sv
module iop_slave
    import iop_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               MODE_W = 4,
    parameter int               DEV_W  = 4,
    parameter logic [DEV_W-1:0] DEV_ID = 4'h5,
    localparam int              ADDR_W = DEV_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic              per_req,
    output logic              per_we,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_ack,
    input  logic              per_fault,
    output logic [MODE_W-1:0] per_mode
);

    cmd_e cmd;

    iop_decode #(
        .DEV_W  (DEV_W),
        .DEV_ID (DEV_ID)
    ) u_decode (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .cmd      (cmd)
    );

    iop_core #(
        .DATA_W (DATA_W),
        .MODE_W (MODE_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid),
        .irq       (irq),
        .per_req   (per_req),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .per_rdata (per_rdata),
        .per_ack   (per_ack),
        .per_fault (per_fault),
        .per_mode  (per_mode)
    );

endmodule

// File: rtl/iop_checker.sv
module iop_checker
    import iop_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               MODE_W = 4,
    parameter int               DEV_W  = 4,
    parameter logic [DEV_W-1:0] DEV_ID = 4'h5,
    localparam int              ADDR_W = DEV_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic              irq,
    input logic              per_req,
    input logic              per_we,
    input logic [DATA_W-1:0] per_wdata,
    input logic              per_ack,
    input logic [MODE_W-1:0] per_mode
);

    logic             hit;
    logic [OFF_W-1:0] off;

    assign hit = (bus_addr[ADDR_W-1 -: DEV_W] == DEV_ID);
    assign off = bus_addr[OFF_W-1:0];

    p_foreign_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !hit) |=> !bus_rvalid);

    p_rvalid_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd && !bus_wr && hit && off != 2'd3));

    p_req_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_req) |-> $past(bus_wr && hit));

    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && per_ack) |=> !per_req);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !per_ack) |=> (per_req && $stable(per_we) && $stable(per_wdata)));

    p_irq_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(hit && (bus_wr || (bus_rd && off == OFF_DATA)))) |=> irq);

    p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && bus_wr && hit && off == OFF_CTRL) |=> $stable(per_mode));

    p_foreign_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(per_mode));

endmodule

bind iop_slave iop_checker #(
    .DATA_W (DATA_W),
    .MODE_W (MODE_W),
    .DEV_W  (DEV_W),
    .DEV_ID (DEV_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .per_req    (per_req),
    .per_we     (per_we),
    .per_wdata  (per_wdata),
    .per_ack    (per_ack),
    .per_mode   (per_mode)
);

// File: tb/iop_slave_tb.sv
`timescale 1ns/1ps
module iop_slave_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid, irq, per_req, per_we;
    logic [7:0] per_wdata;
    logic [7:0] per_rdata = '0;
    logic       per_ack = 1'b0, per_fault = 1'b0;
    logic [3:0] per_mode;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    iop_slave dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq), .per_req(per_req), .per_we(per_we),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ack(per_ack),
        .per_fault(per_fault), .per_mode(per_mode)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference model, one update per clock
    int  m_ctrl, m_data, m_wbuf, m_rdata;
    bit  m_rvalid, m_req, m_we, m_done, m_ovr, m_fault;

    always @(posedge clk) begin
        bit  hit, fin;
        int  off, stat;
        if (!rst_n) begin
            m_ctrl = 0; m_data = 0; m_wbuf = 0; m_rdata = 0;
            m_rvalid = 0; m_req = 0; m_we = 0; m_done = 0; m_ovr = 0; m_fault = 0;
        end else begin
            hit  = (bus_addr[5:2] == 4'd5);
            off  = int'(bus_addr[1:0]);
            fin  = m_req && per_ack;
            stat = int'(m_done) + 2 * int'(m_req) + 4 * int'(m_ovr) + 8 * int'(m_fault);
            m_rvalid = 0;
            if (hit && bus_wr) begin
                if (off != 3 && m_req) m_ovr = 1;
                else if (off == 2) m_ctrl = int'(bus_wdata);
                else if (off == 1) begin m_req = 1; m_we = 0; m_done = 0; end
                else if (off == 0) begin m_req = 1; m_we = 1; m_wbuf = int'(bus_wdata); m_done = 0; end
            end else if (hit && bus_rd && off != 3) begin
                m_rvalid = 1;
                if (off == 0) begin m_rdata = m_data; m_done = 0; end
                else if (off == 1) begin m_rdata = stat; m_ovr = 0; m_fault = 0; end
                else m_rdata = m_ctrl;
            end
            if (fin) begin
                m_req = 0; m_done = 1;
                if (!m_we) m_data = int'(per_rdata);
                if (per_fault) m_fault = 1;
            end
        end
        #1;
        if (rst_n) begin
            chk("R3 model rvalid", int'(bus_rvalid), int'(m_rvalid));
            if (m_rvalid) chk("R6 model rdata", int'(bus_rdata), m_rdata);
            chk("R4 model per_req", int'(per_req), int'(m_req));
            if (m_req) chk("R5 model per_we", int'(per_we), int'(m_we));
            if (m_req && m_we) chk("R5 model per_wdata", int'(per_wdata), m_wbuf);
            chk("R8 model irq", int'(irq), int'(m_done && m_ctrl[0]));
            chk("R2 model per_mode", int'(per_mode), (m_ctrl >> 4) & 15);
        end
    end

    // drive one cycle of inputs at posedge+2, return at the next posedge+2
    task automatic step(input bit wr, input bit rd, input logic [3:0] dev,
                        input logic [1:0] off, input logic [7:0] wd,
                        input bit ack, input logic [7:0] prd, input bit flt);
        bus_wr = wr; bus_rd = rd; bus_addr = {dev, off}; bus_wdata = wd;
        per_ack = ack; per_rdata = prd; per_fault = flt;
        @(posedge clk); #2;
    endtask

    task automatic idle();
        step(0, 0, 4'd0, 2'd0, 8'h00, 0, 8'h00, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        chk("R4 reset per_req", int'(per_req), 0);
        chk("R8 reset irq", int'(irq), 0);
        chk("R3 reset rvalid", int'(bus_rvalid), 0);

        // control register
        step(1, 0, 4'd5, 2'd2, 8'hA0, 0, 8'h00, 0);
        chk("R2 mode", int'(per_mode), 'hA);
        step(0, 1, 4'd5, 2'd2, 8'h00, 0, 8'h00, 0);
        chk("R2 ctrl read", int'(bus_rdata), 'hA0);

        // foreign device
        step(1, 0, 4'd3, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R1 foreign fetch", int'(per_req), 0);
        step(1, 0, 4'd3, 2'd2, 8'h50, 0, 8'h00, 0);
        chk("R1 foreign ctrl", int'(per_mode), 'hA);
        step(0, 1, 4'd3, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R1 foreign read", int'(bus_rvalid), 0);

        // polled fetch with a refused send
        step(1, 0, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R4 req up", int'(per_req), 1);
        chk("R4 we low", int'(per_we), 0);
        idle();
        chk("R4 req held", int'(per_req), 1);
        step(0, 1, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R3 status busy", int'(bus_rdata), 'h02);
        step(1, 0, 4'd5, 2'd0, 8'h77, 0, 8'h00, 0);
        chk("R9 send refused", int'(per_we), 0);
        step(0, 1, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R9 overrun bit", int'(bus_rdata), 'h06);
        step(0, 0, 4'd0, 2'd0, 8'h00, 1, 8'h3C, 0);
        chk("R4 req drop", int'(per_req), 0);
        chk("R7 polled irq", int'(irq), 0);
        step(0, 1, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R3 status done", int'(bus_rdata), 'h01);
        step(0, 1, 4'd5, 2'd0, 8'h00, 0, 8'h00, 0);
        chk("R6 data", int'(bus_rdata), 'h3C);
        step(0, 1, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R6 done cleared", int'(bus_rdata), 'h00);

        // interrupt mode send with fault
        step(1, 0, 4'd5, 2'd2, 8'h01, 0, 8'h00, 0);
        step(1, 0, 4'd5, 2'd0, 8'h5A, 0, 8'h00, 0);
        chk("R5 req", int'(per_req), 1);
        chk("R5 we", int'(per_we), 1);
        chk("R5 wdata", int'(per_wdata), 'h5A);
        idle();
        chk("R5 wdata held", int'(per_wdata), 'h5A);
        step(0, 0, 4'd0, 2'd0, 8'h00, 1, 8'hEE, 1);
        chk("R8 irq up", int'(irq), 1);
        step(0, 1, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R10 fault bit", int'(bus_rdata), 'h09);
        step(0, 1, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R3 fault cleared", int'(bus_rdata), 'h01);
        chk("R8 irq kept", int'(irq), 1);
        step(0, 1, 4'd5, 2'd0, 8'h00, 0, 8'h00, 0);
        chk("R5 send leaves data", int'(bus_rdata), 'h3C);
        chk("R8 irq cleared", int'(irq), 0);

        // same-cycle completion and data read
        step(1, 0, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        step(0, 1, 4'd5, 2'd0, 8'h00, 1, 8'hC3, 0);
        chk("R11 old data", int'(bus_rdata), 'h3C);
        chk("R11 done survives", int'(irq), 1);
        step(0, 1, 4'd5, 2'd0, 8'h00, 0, 8'h00, 0);
        chk("R11 new data", int'(bus_rdata), 'hC3);

        // same-cycle completion and status read
        step(1, 0, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        step(0, 1, 4'd5, 2'd1, 8'h00, 1, 8'h11, 0);
        chk("R11 old status", int'(bus_rdata), 'h02);
        step(0, 1, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        chk("R11 status after", int'(bus_rdata), 'h01);
        step(0, 1, 4'd5, 2'd0, 8'h00, 0, 8'h00, 0);
        chk("R4 fetched byte", int'(bus_rdata), 'h11);

        // reserved offset
        step(0, 1, 4'd5, 2'd3, 8'h00, 0, 8'h00, 0);
        chk("R12 no response", int'(bus_rvalid), 0);
        step(1, 0, 4'd5, 2'd3, 8'hFF, 0, 8'h00, 0);
        chk("R12 no request", int'(per_req), 0);
        chk("R12 mode kept", int'(per_mode), 0);

        // control write refused while busy
        step(1, 0, 4'd5, 2'd1, 8'h00, 0, 8'h00, 0);
        step(1, 0, 4'd5, 2'd2, 8'hF0, 0, 8'h00, 0);
        chk("R9 mode locked", int'(per_mode), 0);
        step(0, 1, 4'd5, 2'd1, 8'h00, 1, 8'h22, 0);
        chk("R9 overrun on ctrl", int'(bus_rdata), 'h06);
        step(0, 1, 4'd5, 2'd2, 8'h00, 0, 8'h00, 0);
        chk("R9 ctrl unchanged", int'(bus_rdata), 'h01);
        idle();
        idle();

        finish_run();
    end

endmodule